// File: doc/BRIEF.md
# RS485 Half-Duplex Direction Controller

This block steers a half-duplex RS485 transceiver around each outgoing frame. It drives the RTS pin, which serves as the transceiver's driver enable. It also drives a receiver-enable line into the UART receive path, so that the block's own echo never reaches the receive FIFO. The receiver is blocked through that dedicated enable rather than by masking an interrupt, because a masked interrupt still leaves the data-ready status set.

A transmit-start request opens a frame. In a gated frame the receiver is switched off first, and one cycle later RTS moves to its send level. The frame closes once the transmitter has been seen busy and then becomes fully drained: the FIFO is empty and the shifter is idle, so the last stop bit has left the line. At that point RTS moves to its after-send level, and one cycle later the receiver is switched back on. The RTS control bit is held inverted relative to the pin, so a cleared bit drives the pin high. A busy flag reports a frame in progress.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset rtsPin is 0 (control bit set), rxEnable is 1, txEnable is 1 and busy is 0.
- R2: rtsPin is always the inverse of the internal RTS control bit. Writing the bit 0 drives the pin 1, and writing it 1 drives the pin 0.
- R3: At the clock edge that samples txStartReq=1 while busy is 0, busy becomes 1. At that same edge rxEnable becomes 0 if cfgRxDuringTx=1'b0. rtsPin does not change at that edge.
- R4: At the edge after the start edge, rtsPin takes the value of cfgRtsOnSend (pin 1 when the option is 1).
- R5: The frame ends at the first edge at which txFifoEmpty=1 and txShiftIdle=1 after an earlier edge in the frame saw the transmitter not idle. At that edge rtsPin takes the value of cfgRtsAfterSend.
- R6: One edge after the RTS stop update, busy returns to 0 and rxEnable returns to 1. While busy is 0, rxEnable is 1.
- R7: cfgRxDuringTx is sampled at the start edge only. If it was 1, rxEnable stays 1 for the whole frame. Later changes to it within the frame do not affect rxEnable.
- R8: txStartReq is ignored while busy is 1. Back-to-back data inside a frame keeps rtsPin at its send level.
- R9: txEnable stays 1 at all times.
- R10: While busy is 0, rtsPin holds its value, and changes to the configuration inputs do not move rtsPin or rxEnable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txStartReq | input | 1 | Request to begin a transmission |
| txFifoEmpty | input | 1 | Transmit FIFO holds no data |
| txShiftIdle | input | 1 | Transmit shift register has finished |
| cfgRtsOnSend | input | 1 | RTS pin level while sending |
| cfgRtsAfterSend | input | 1 | RTS pin level after sending |
| cfgRxDuringTx | input | 1 | Allow reception during transmit |
| rtsPin | output | 1 | RTS / driver-enable pin level |
| rxEnable | output | 1 | Receiver enable to UART receive path |
| txEnable | output | 1 | Transmitter enable |
| busy | output | 1 | Transmission in progress |

## Verification
The bench builds the block with RTS_INVERTED=1, which is the inverted control-bit variant under study. This brings into reach the mapping from a cleared control bit to a high pin, at both the start and the stop of a frame. Directed frames cover the two-step orderings at start and stop, a transmitter that drains its FIFO while the shifter is still busy, restart requests inside a frame, and changes to the receive-gating option in the middle of a frame. Random input streams with a fixed seed then run against a cycle model written in the bench.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RXOFF  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_RXON   = 2'd3
  } dirState_t;

  // One-cycle write strobes from control to the register datapath
  typedef struct packed {
    logic rxOff;     // clear receiver enable
    logic rtsSend;   // load RTS control with send level
    logic rtsAfter;  // load RTS control with after-send level
    logic rxOn;      // set receiver enable
  } dirStrobe_t;

endpackage

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txStartReq,
  input  logic       txFifoEmpty,
  input  logic       txShiftIdle,
  input  logic       cfgRxDuringTx,
  output dirStrobe_t strobe,
  output logic       busy
);

  dirState_t state, stateNext;
  logic      sawBusy, sawBusyNext;
  logic      gateRx, gateRxNext;
  logic      txDrained;

  assign txDrained = txFifoEmpty & txShiftIdle;

  always_comb begin
    stateNext   = state;
    sawBusyNext = sawBusy;
    gateRxNext  = gateRx;
    strobe      = '0;
    unique case (state)
      ST_IDLE: begin
        sawBusyNext = 1'b0;
        if (txStartReq) begin
          stateNext    = ST_RXOFF;
          gateRxNext   = ~cfgRxDuringTx;
          strobe.rxOff = ~cfgRxDuringTx;
        end
      end
      ST_RXOFF: begin
        strobe.rtsSend = 1'b1;
        sawBusyNext    = sawBusy | ~txDrained;
        stateNext      = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (sawBusy && txDrained) begin
          strobe.rtsAfter = 1'b1;
          stateNext       = ST_RXON;
        end else begin
          sawBusyNext = sawBusy | ~txDrained;
        end
      end
      ST_RXON: begin
        strobe.rxOn = gateRx;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sawBusy <= 1'b0;
      gateRx  <= 1'b0;
    end else begin
      state   <= stateNext;
      sawBusy <= sawBusyNext;
      gateRx  <= gateRxNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/rs485_dir_regs.sv
module rs485_dir_regs
  import rs485_dir_pkg::*;
#(
  parameter bit RTS_INVERTED = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  dirStrobe_t strobe,
  input  logic       cfgRtsOnSend,
  input  logic       cfgRtsAfterSend,
  output logic       rtsPin,
  output logic       rxEnable,
  output logic       txEnable
);

  // Control bit value that leaves the pin low after reset
  localparam logic RTS_CTRL_RST = RTS_INVERTED;

  logic rtsCtrl;
  logic rxEnBit;
  logic txEnBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtsCtrl <= RTS_CTRL_RST;
      rxEnBit <= 1'b1;
      txEnBit <= 1'b1;
    end else begin
      if (strobe.rtsSend)       rtsCtrl <= cfgRtsOnSend ^ RTS_INVERTED;
      else if (strobe.rtsAfter) rtsCtrl <= cfgRtsAfterSend ^ RTS_INVERTED;
      if (strobe.rxOff)         rxEnBit <= 1'b0;
      else if (strobe.rxOn)     rxEnBit <= 1'b1;
      txEnBit <= txEnBit;
    end
  end

  generate
    if (RTS_INVERTED) begin : g_inv
      assign rtsPin = ~rtsCtrl;
    end else begin : g_direct
      assign rtsPin = rtsCtrl;
    end
  endgenerate

  assign rxEnable = rxEnBit;
  assign txEnable = txEnBit;

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter bit RTS_INVERTED = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic txStartReq,
  input  logic txFifoEmpty,
  input  logic txShiftIdle,
  input  logic cfgRtsOnSend,
  input  logic cfgRtsAfterSend,
  input  logic cfgRxDuringTx,
  output logic rtsPin,
  output logic rxEnable,
  output logic txEnable,
  output logic busy
);

  dirStrobe_t strobe;

  rs485_dir_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .txStartReq   (txStartReq),
    .txFifoEmpty  (txFifoEmpty),
    .txShiftIdle  (txShiftIdle),
    .cfgRxDuringTx(cfgRxDuringTx),
    .strobe       (strobe),
    .busy         (busy)
  );

  rs485_dir_regs #(.RTS_INVERTED(RTS_INVERTED)) u_regs (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .cfgRtsOnSend   (cfgRtsOnSend),
    .cfgRtsAfterSend(cfgRtsAfterSend),
    .rtsPin         (rtsPin),
    .rxEnable       (rxEnable),
    .txEnable       (txEnable)
  );

endmodule

// File: rtl/rs485_dir_chk.sv
module rs485_dir_chk (
  input logic clk,
  input logic rstN,
  input logic cfgRxDuringTx,
  input logic rtsPin,
  input logic rxEnable,
  input logic txEnable,
  input logic busy
);

  assert_rx_off_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxEnable) |-> ($stable(rtsPin) && $rose(busy)));

  assert_rx_on_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnable) |-> (!busy && $stable(rtsPin)));

  assert_rx_on_when_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> rxEnable);

  assert_rx_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && $past(cfgRxDuringTx)) |-> rxEnable);

  assert_tx_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    txEnable);

  assert_rts_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rtsPin) |-> $past(busy));

endmodule

bind rs485_dir_ctrl rs485_dir_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgRxDuringTx(cfgRxDuringTx),
  .rtsPin       (rtsPin),
  .rxEnable     (rxEnable),
  .txEnable     (txEnable),
  .busy         (busy)
);

// File: tb/sim_rs485_dir_ctrl.sv
`timescale 1ns/1ps
module sim_rs485_dir_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txStartReq = 1'b0, txFifoEmpty = 1'b1, txShiftIdle = 1'b1;
  logic cfgRtsOnSend = 1'b1, cfgRtsAfterSend = 1'b0, cfgRxDuringTx = 1'b0;
  logic rtsPin, rxEnable, txEnable, busy;

  int checks = 0;
  int errors = 0;

  // reference model state
  int   mSt = 0;
  logic mSaw = 1'b0, mGate = 1'b0, mRts = 1'b0, mRx = 1'b1;

  always #4 clk = ~clk;

  rs485_dir_ctrl #(.RTS_INVERTED(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .txStartReq(txStartReq), .txFifoEmpty(txFifoEmpty),
    .txShiftIdle(txShiftIdle), .cfgRtsOnSend(cfgRtsOnSend),
    .cfgRtsAfterSend(cfgRtsAfterSend), .cfgRxDuringTx(cfgRxDuringTx),
    .rtsPin(rtsPin), .rxEnable(rxEnable), .txEnable(txEnable), .busy(busy)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // model of one clock edge, written from the requirements
  task automatic modelEdge();
    logic drained;
    drained = txFifoEmpty & txShiftIdle;
    case (mSt)
      0: begin
        mSaw = 1'b0;
        if (txStartReq) begin
          mSt = 1; mGate = ~cfgRxDuringTx;
          if (!cfgRxDuringTx) mRx = 1'b0;
        end
      end
      1: begin mRts = cfgRtsOnSend; mSaw = mSaw | ~drained; mSt = 2; end
      2: begin
        if (mSaw && drained) begin mRts = cfgRtsAfterSend; mSt = 3; end
        else mSaw = mSaw | ~drained;
      end
      default: begin if (mGate) mRx = 1'b1; mSt = 0; end
    endcase
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk({tag, " rtsPin"}, rtsPin, mRts);
    chk({tag, " rxEnable"}, rxEnable, mRx);
    chk({"R9 txEnable"}, txEnable, 1'b1);
    chk({tag, " busy"}, busy, (mSt != 0));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rtsPin", rtsPin, 1'b0);
    chk("R1 rxEnable", rxEnable, 1'b1);
    chk("R1 txEnable", txEnable, 1'b1);
    chk("R1 busy", busy, 1'b0);
    rstN = 1'b1;

    // Gated frame, pin high during send (R2, R3, R4, R5, R6)
    cfgRtsOnSend = 1'b1; cfgRtsAfterSend = 1'b0; cfgRxDuringTx = 1'b0;
    txStartReq = 1'b1;
    tick("R3");
    chk("R3 rx off at start", rxEnable, 1'b0);
    chk("R3 rts unchanged at start", rtsPin, 1'b0);
    txStartReq = 1'b0; txFifoEmpty = 1'b0; txShiftIdle = 1'b0;
    tick("R4");
    chk("R2 R4 pin high for send", rtsPin, 1'b1);
    repeat (3) tick("R8");
    txFifoEmpty = 1'b1;
    repeat (2) tick("R5");
    chk("R5 still busy while shifter runs", busy, 1'b1);
    txShiftIdle = 1'b1;
    tick("R5");
    chk("R5 rts after-send", rtsPin, 1'b0);
    chk("R6 rx still off", rxEnable, 1'b0);
    tick("R6");
    chk("R6 rx back on", rxEnable, 1'b1);
    chk("R6 idle", busy, 1'b0);

    // Restart requests inside a frame are ignored (R8)
    txStartReq = 1'b1;
    tick("R8");
    txFifoEmpty = 1'b0; txShiftIdle = 1'b0;
    repeat (6) tick("R8");
    chk("R8 rts stays send level", rtsPin, 1'b1);
    txStartReq = 1'b0; txFifoEmpty = 1'b1; txShiftIdle = 1'b1;
    repeat (3) tick("R8");

    // Ungated frame, option flipped mid-frame (R7)
    cfgRxDuringTx = 1'b1; cfgRtsOnSend = 1'b0; cfgRtsAfterSend = 1'b1;
    txStartReq = 1'b1;
    tick("R7");
    txStartReq = 1'b0; cfgRxDuringTx = 1'b0; txFifoEmpty = 1'b0;
    tick("R7");
    chk("R7 rx kept on", rxEnable, 1'b1);
    chk("R2 R4 pin low for send", rtsPin, 1'b0);
    txFifoEmpty = 1'b1;
    repeat (3) tick("R7");
    chk("R5 after-send high", rtsPin, 1'b1);

    // Gated frame with option raised mid-frame: rx still restored (R7)
    cfgRxDuringTx = 1'b0;
    txStartReq = 1'b1;
    tick("R7");
    txStartReq = 1'b0; cfgRxDuringTx = 1'b1; txShiftIdle = 1'b0;
    repeat (3) tick("R7");
    chk("R7 rx stays off", rxEnable, 1'b0);
    txShiftIdle = 1'b1;
    repeat (3) tick("R7");
    chk("R7 rx restored", rxEnable, 1'b1);

    // Idle configuration changes have no effect (R10)
    cfgRtsOnSend = 1'b1; cfgRtsAfterSend = 1'b0; cfgRxDuringTx = 1'b0;
    repeat (4) tick("R10");
    chk("R10 rts held", rtsPin, 1'b1);
    chk("R10 rx held", rxEnable, 1'b1);

    // Random streams against the model
    for (int i = 0; i < 4000; i++) begin
      txStartReq  = ($urandom % 6) == 0;
      txFifoEmpty = ($urandom % 3) != 0;
      txShiftIdle = ($urandom % 2) == 0;
      if (($urandom % 12) == 0) cfgRtsOnSend    = $urandom;
      if (($urandom % 12) == 0) cfgRtsAfterSend = $urandom;
      if (($urandom % 12) == 0) cfgRxDuringTx   = $urandom;
      tick("R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule